// File: doc/BRIEF.md
# Boot-Filled Protected High RAM Window

This block is the memory front end of a microcontroller's shared RAM. After a cold reset it streams a boot image, one byte at a time, from a serial ROM port into the top slice of physical RAM. Until that copy is finished the bus reports busy. After the copy, a flat address space decodes into three regions: low RAM mapped straight through, an empty gap, and a window at the very top of the address space. That top window is the only way to reach the last slice of physical RAM.

The window can be locked against writes. The lock is set and cleared by a sub-command carried inside the 32-bit clock configuration word. Clock commands and lock commands share the one strobe, and neither kind changes the state the other controls. The block forwards clock commands to the clock generator.

The full-size instance is `ADDR_W=20`, `RAM_BYTES=524288` and `WIN_BYTES=16384`. That size gives a 496 KB low region, a gap from 0x7C000 to 0xFBFFF, and a window at 0xFC000 to 0xFFFFF, filled in 32K clocks. The default parameters are a scaled copy with the same layout, so the RAM array stays small.

Top module: `hubram_window`

## Requirements
- R1: An address below `RAM_BYTES-WIN_BYTES` reads and writes physical RAM at that same address.
- R2: Addresses from `RAM_BYTES-WIN_BYTES` up to `2**ADDR_W-WIN_BYTES-1` form the gap. A read there returns 0x00, and a write there changes no RAM location.
- R3: The top `WIN_BYTES` addresses of the space reach the last `WIN_BYTES` of physical RAM, in order. After a cold boot, window byte i holds ROM byte i.
- R4: After cold reset is released, `ready_o` stays low for exactly `2*WIN_BYTES` clock edges. During that time the ROM is read at addresses 0, 1, 2 … in turn, with a request on every second cycle.
- R5: A request made while `ready_o` is low is held by the requester and completes once `ready_o` rises. It is not lost.
- R6: A config write whose bits [31:29] are 3'b001 and whose bit 28 is 1 locks the window. While the lock is on, writes to the window are dropped and reads return the stored data. Writes to low RAM still take effect.
- R7: A config write whose bits [31:29] are 3'b001 and whose bit 28 is 0 unlocks the window, so later window writes take effect.
- R8: A lock or unlock command leaves `clk_cfg_o` unchanged. Any other config write copies the whole word to `clk_cfg_o` and leaves the lock state unchanged.
- R9: Any reset (cold or warm) clears the lock and returns `clk_cfg_o` to `CLK_CFG_RST`. A warm reset does not repeat the ROM copy: `ready_o` stays high and RAM contents are kept.
- R10: Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the clock edge that accepts the read (`req_i` and `ready_o` both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Cold reset, active low, synchronous; starts the ROM copy |
| rst_n_i | input | 1 | Warm reset, active low, synchronous |
| req_i | input | 1 | Bus request, held until accepted |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | High when a request can be accepted |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |
| rom_rd_o | output | 1 | ROM byte read strobe |
| rom_addr_o | output | log2(WIN_BYTES) | ROM byte address |
| rom_data_i | input | 8 | ROM byte, valid the cycle after the strobe |
| cfg_we_i | input | 1 | Configuration word strobe |
| cfg_data_i | input | 32 | Configuration word |
| clk_cfg_o | output | 32 | Clock setting forwarded to the clock generator |

## Verification
After a read is accepted, its data and `rvalid_o` are due at the next clock edge. A config write takes effect at the edge that samples the strobe. `ready_o` is due exactly `2*WIN_BYTES` edges after cold reset is released. The driver pushes each expected read value into a queue before the request goes out. The monitor then compares only in cycles where `rvalid_o` is high, and the driver itself checks that `rvalid_o` is high one cycle after acceptance. Boot timing is measured by counting edges from the release of reset, while a stalled read is pending at the same time.

// File: rtl/hubram_window_pkg.sv
package hubram_window_pkg;

   localparam int BYTE_W     = 8;
   localparam int CFG_W      = 32;
   localparam int PROT_BIT   = 28;
   localparam logic [2:0] PROT_CODE = 3'b001;

   typedef enum logic [1:0] {
      RG_LOW = 2'd0,
      RG_GAP = 2'd1,
      RG_WIN = 2'd2
   } region_e;

   function automatic logic is_prot_cmd(input logic [CFG_W-1:0] w);
      return w[CFG_W-1 -: 3] == PROT_CODE;
   endfunction

endpackage

// File: rtl/hubram_window_decode.sv
module hubram_window_decode
   import hubram_window_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int RAM_BYTES = 2048,
   parameter int WIN_BYTES = 512,
   localparam int PHYS_AW  = $clog2(RAM_BYTES),
   localparam int WIN_AW   = $clog2(WIN_BYTES)
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output region_e            rg_o,
   output logic [PHYS_AW-1:0] phys_o
);
   localparam int LOW_BYTES = RAM_BYTES - WIN_BYTES;
   localparam longint SPACE = longint'(1) << ADDR_W;
   localparam longint WIN_BASE = SPACE - WIN_BYTES;

   logic win_hit;
   logic low_hit;

   assign win_hit = &addr_i[ADDR_W-1:WIN_AW];

   generate
      if (longint'(LOW_BYTES) == WIN_BASE) begin : g_no_gap
         assign low_hit = !win_hit;
      end else begin : g_gap
         assign low_hit = {1'b0, addr_i} < (ADDR_W+1)'(LOW_BYTES);
      end
   endgenerate

   always_comb begin
      rg_o   = RG_GAP;
      phys_o = '0;
      if (win_hit) begin
         rg_o   = RG_WIN;
         phys_o = PHYS_AW'(LOW_BYTES) + PHYS_AW'(addr_i[WIN_AW-1:0]);
      end else if (low_hit) begin
         rg_o   = RG_LOW;
         phys_o = addr_i[PHYS_AW-1:0];
      end
   end

endmodule

// File: rtl/hubram_window_boot.sv
module hubram_window_boot
   import hubram_window_pkg::*;
#(
   parameter int RAM_BYTES = 2048,
   parameter int WIN_BYTES = 512,
   localparam int PHYS_AW  = $clog2(RAM_BYTES),
   localparam int WIN_AW   = $clog2(WIN_BYTES)
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   output logic              rom_rd_o,
   output logic [WIN_AW-1:0] rom_addr_o,
   input  logic [BYTE_W-1:0] rom_data_i,
   output logic              wr_en_o,
   output logic [PHYS_AW-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              done_o
);
   localparam int LOW_BYTES = RAM_BYTES - WIN_BYTES;
   localparam logic [WIN_AW-1:0] LAST_IDX = WIN_AW'(WIN_BYTES - 1);

   logic [WIN_AW-1:0] idx_q;
   logic              fetch_q;
   logic              done_q;

   // fetch_q = 0: issue ROM read; fetch_q = 1: byte arrives, store it
   always_ff @(posedge clk_i) begin
      if (!por_n_i) begin
         idx_q   <= '0;
         fetch_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (!done_q) begin
         if (!fetch_q) begin
            fetch_q <= 1'b1;
         end else begin
            fetch_q <= 1'b0;
            idx_q   <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) done_q <= 1'b1;
         end
      end
   end

   assign rom_rd_o   = !done_q && !fetch_q;
   assign rom_addr_o = idx_q;
   assign wr_en_o    = !done_q && fetch_q;
   assign wr_addr_o  = PHYS_AW'(LOW_BYTES) + PHYS_AW'(idx_q);
   assign wr_data_o  = rom_data_i;
   assign done_o     = done_q;

   // R4
   rom_two_clk_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rom_rd_o |=> !rom_rd_o);

   // R4
   rom_addr_step_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wr_en_o && !done_o |=> (rom_rd_o && rom_addr_o == $past(rom_addr_o) + 1'b1) || done_o);

   // R4
   boot_done_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      done_o |=> done_o);

endmodule

// File: rtl/hubram_window_cfg.sv
module hubram_window_cfg
   import hubram_window_pkg::*;
#(
   parameter logic [CFG_W-1:0] CLK_CFG_RST = '0
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_data_i,
   output logic             prot_o,
   output logic [CFG_W-1:0] clk_cfg_o
);
   logic prot_q;
   logic [CFG_W-1:0] clk_q;
   logic cmd_is_prot;

   assign cmd_is_prot = is_prot_cmd(cfg_data_i);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         prot_q <= 1'b0;
         clk_q  <= CLK_CFG_RST;
      end else if (cfg_we_i) begin
         if (cmd_is_prot) prot_q <= cfg_data_i[PROT_BIT];
         else             clk_q  <= cfg_data_i;
      end
   end

   assign prot_o    = prot_q;
   assign clk_cfg_o = clk_q;

   // R8
   prot_keeps_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cfg_we_i && cmd_is_prot |=> $stable(clk_cfg_o));

   // R8
   clk_keeps_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      cfg_we_i && !cmd_is_prot |=> $stable(prot_o));

endmodule

// File: rtl/hubram_window.sv
module hubram_window
   import hubram_window_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int RAM_BYTES = 2048,
   parameter int WIN_BYTES = 512,
   parameter logic [31:0] CLK_CFG_RST = 32'h0000_0000,
   localparam int WIN_AW   = $clog2(WIN_BYTES)
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              rst_n_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic              ready_o,
   output logic              rvalid_o,
   output logic [7:0]        rdata_o,
   output logic              rom_rd_o,
   output logic [WIN_AW-1:0] rom_addr_o,
   input  logic [7:0]        rom_data_i,
   input  logic              cfg_we_i,
   input  logic [31:0]       cfg_data_i,
   output logic [31:0]       clk_cfg_o
);
   localparam int PHYS_AW   = $clog2(RAM_BYTES);
   localparam int LOW_BYTES = RAM_BYTES - WIN_BYTES;

   generate
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0 || WIN_BYTES < 2) begin : g_bad_win
         $error("WIN_BYTES must be a power of two of at least 2");
      end
      if ((RAM_BYTES & (RAM_BYTES - 1)) != 0 || RAM_BYTES <= WIN_BYTES) begin : g_bad_ram
         $error("RAM_BYTES must be a power of two larger than WIN_BYTES");
      end
      if (PHYS_AW > ADDR_W) begin : g_bad_space
         $error("RAM_BYTES does not fit in the address space");
      end
   endgenerate

   logic rst_all_n;
   assign rst_all_n = por_n_i && rst_n_i;

   region_e            rg;
   logic [PHYS_AW-1:0] phys;
   logic               prot;
   logic               cp_we;
   logic [PHYS_AW-1:0] cp_addr;
   logic [7:0]         cp_data;
   logic               boot_done;

   hubram_window_decode #(
      .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .WIN_BYTES(WIN_BYTES)
   ) u_dec (
      .addr_i(addr_i), .rg_o(rg), .phys_o(phys)
   );

   hubram_window_boot #(
      .RAM_BYTES(RAM_BYTES), .WIN_BYTES(WIN_BYTES)
   ) u_boot (
      .clk_i(clk_i), .por_n_i(por_n_i),
      .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
      .wr_en_o(cp_we), .wr_addr_o(cp_addr), .wr_data_o(cp_data),
      .done_o(boot_done)
   );

   hubram_window_cfg #(
      .CLK_CFG_RST(CLK_CFG_RST)
   ) u_cfg (
      .clk_i(clk_i), .rst_n_i(rst_all_n),
      .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
      .prot_o(prot), .clk_cfg_o(clk_cfg_o)
   );

   logic acc;
   logic bus_we;
   logic rd_acc;

   assign ready_o = boot_done;
   assign acc     = req_i && ready_o && rst_all_n;
   assign rd_acc  = acc && !we_i;
   assign bus_we  = acc && we_i &&
                    ((rg == RG_LOW) || (rg == RG_WIN && !prot));

   logic [7:0] ram [RAM_BYTES];
   logic [7:0] ram_q;
   logic       gap_q;
   logic       rvalid_q;

   always_ff @(posedge clk_i) begin
      if (cp_we)       ram[cp_addr] <= cp_data;
      else if (bus_we) ram[phys]    <= wdata_i;
      if (rd_acc)      ram_q        <= ram[phys];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_all_n) begin
         rvalid_q <= 1'b0;
         gap_q    <= 1'b0;
      end else begin
         rvalid_q <= rd_acc;
         if (rd_acc) gap_q <= (rg == RG_GAP);
      end
   end

   assign rvalid_o = rvalid_q;
   assign rdata_o  = gap_q ? 8'h00 : ram_q;

   // R10
   rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      req_i && ready_o && !we_i |=> rvalid_o);

   // R2
   gap_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      req_i && ready_o && !we_i && rg == RG_GAP |=> rdata_o == 8'h00);

   // R5
   no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      !ready_o |=> !rvalid_o);

endmodule

// File: tb/tb_hubram_window.sv
module tb_hubram_window;
   localparam int ADDR_W    = 12;
   localparam int RAM_BYTES = 2048;
   localparam int WIN_BYTES = 512;
   localparam int WIN_AW    = $clog2(WIN_BYTES);
   localparam int SPACE     = 1 << ADDR_W;
   localparam int LOW_BYTES = RAM_BYTES - WIN_BYTES;
   localparam int WIN_BASE  = SPACE - WIN_BYTES;
   localparam logic [31:0] CLK_RST = 32'h0000_00A0;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic por_n = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic ready_o, rvalid_o;
   logic [7:0] rdata_o;
   logic rom_rd_o;
   logic [WIN_AW-1:0] rom_addr_o;
   logic [7:0] rom_data = '0;
   logic cfg_we = 1'b0;
   logic [31:0] cfg_data = '0;
   logic [31:0] clk_cfg_o;

   hubram_window #(
      .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .WIN_BYTES(WIN_BYTES),
      .CLK_CFG_RST(CLK_RST)
   ) dut (
      .clk_i(clk), .por_n_i(por_n), .rst_n_i(rst_n),
      .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
      .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data),
      .cfg_we_i(cfg_we), .cfg_data_i(cfg_data), .clk_cfg_o(clk_cfg_o)
   );

   function automatic logic [7:0] rom_fn(input int i);
      return 8'((i * 29) + (i >> 3) + 7);
   endfunction

   // ROM model: byte valid the cycle after the strobe
   always @(posedge clk) if (rom_rd_o) rom_data <= rom_fn(int'(rom_addr_o));

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   logic [7:0] m_low [LOW_BYTES];
   logic [7:0] m_win [WIN_BYTES];
   bit prot_m = 1'b0;

   function automatic logic [7:0] exp_read(input int a);
      if (a >= WIN_BASE) return m_win[a - WIN_BASE];
      if (a < LOW_BYTES) return m_low[a];
      return 8'h00;
   endfunction

   typedef struct { int a; logic [7:0] d; string tag; } exp_t;
   exp_t sb[$];

   // monitor
   always @(negedge clk) begin
      if (rvalid_o && !finished) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10 unexpected read data", int'(rdata_o), 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rdata_o === e.d, e.tag, int'(rdata_o), int'(e.d));
         end
      end
   end

   task automatic bus_op(input bit w, input int a, input logic [7:0] d, input string tag);
      @(negedge clk);
      req = 1'b1; we = w; addr = ADDR_W'(a); wdata = d;
      if (!w) sb.push_back('{a: a, d: exp_read(a), tag: tag});
      while (!ready_o) @(negedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      if (!w) chk(rvalid_o === 1'b1, "R10 rvalid one cycle after accept", int'(rvalid_o), 1);
      else if (a >= WIN_BASE) begin
         if (!prot_m) m_win[a - WIN_BASE] = d;
      end else if (a < LOW_BYTES) m_low[a] = d;
   endtask

   task automatic cfg_wr(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_data = w;
      @(negedge clk);
      cfg_we = 1'b0;
      if (w[31:29] == 3'b001) prot_m = w[28];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int boot_cycles;
      for (int i = 0; i < WIN_BYTES; i++) m_win[i] = rom_fn(i);

      repeat (4) @(negedge clk);
      // R4 reset state
      chk(ready_o === 1'b0, "R4 ready low in reset", int'(ready_o), 0);
      chk(rvalid_o === 1'b0, "R10 rvalid low in reset", int'(rvalid_o), 0);
      chk(clk_cfg_o === CLK_RST, "R9 clk_cfg reset value", int'(clk_cfg_o), int'(CLK_RST));

      @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      boot_cycles = 0;
      fork
         begin
            forever begin
               @(posedge clk); boot_cycles++;
               @(negedge clk);
               if (ready_o) break;
            end
         end
         begin
            // R5: read held through the boot copy
            bus_op(1'b0, WIN_BASE + 7, 8'h00, "R5 stalled window read");
         end
      join
      chk(boot_cycles == 2 * WIN_BYTES, "R4 boot length", boot_cycles, 2 * WIN_BYTES);

      // R3 full window contents vs ROM
      for (int i = 0; i < WIN_BYTES; i++) bus_op(1'b0, WIN_BASE + i, 8'h00, "R3 window byte");

      // R1 low region
      bus_op(1'b1, 0, 8'h3C, "R1");
      bus_op(1'b1, LOW_BYTES - 1, 8'hC3, "R1");
      bus_op(1'b1, 100, 8'h5A, "R1");
      bus_op(1'b0, 0, 8'h00, "R1 low addr 0");
      bus_op(1'b0, LOW_BYTES - 1, 8'h00, "R1 low last");
      bus_op(1'b0, 100, 8'h00, "R1 low mid");

      // R2 gap writes discarded, reads zero
      bus_op(1'b1, LOW_BYTES, 8'hFF, "R2");
      bus_op(1'b1, WIN_BASE - 1, 8'hEE, "R2");
      for (int a = LOW_BYTES; a < WIN_BASE; a++) bus_op(1'b0, a, 8'h00, "R2 gap read");
      bus_op(1'b0, 0, 8'h00, "R2 low untouched by gap write");
      bus_op(1'b0, WIN_BASE, 8'h00, "R2 window untouched by gap write");

      // R8 clock command
      cfg_wr(32'h4000_1234);
      chk(clk_cfg_o === 32'h4000_1234, "R8 clock command applied", int'(clk_cfg_o), 32'h4000_1234);
      // R6 lock
      cfg_wr(32'h3000_0000);
      chk(clk_cfg_o === 32'h4000_1234, "R8 lock keeps clk_cfg", int'(clk_cfg_o), 32'h4000_1234);
      bus_op(1'b1, WIN_BASE + 10, 8'h99, "R6");
      bus_op(1'b0, WIN_BASE + 10, 8'h00, "R6 locked window write dropped");
      bus_op(1'b1, 20, 8'h77, "R6");
      bus_op(1'b0, 20, 8'h00, "R6 low write while locked");
      // R8 clock command keeps lock
      cfg_wr(32'h8000_0055);
      chk(clk_cfg_o === 32'h8000_0055, "R8 second clock command", int'(clk_cfg_o), 32'h8000_0055);
      bus_op(1'b1, WIN_BASE + 11, 8'h11, "R8");
      bus_op(1'b0, WIN_BASE + 11, 8'h00, "R8 lock kept after clock command");

      // R7 unlock
      cfg_wr(32'h2FFF_FFFF & 32'h2000_0000);
      chk(clk_cfg_o === 32'h8000_0055, "R8 unlock keeps clk_cfg", int'(clk_cfg_o), 32'h8000_0055);
      bus_op(1'b1, WIN_BASE + 10, 8'hB4, "R7");
      bus_op(1'b0, WIN_BASE + 10, 8'h00, "R7 unlocked window write");

      // R9 warm reset
      cfg_wr(32'h3000_0000);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; prot_m = 1'b0;
      chk(ready_o === 1'b1, "R9 no recopy after warm reset", int'(ready_o), 1);
      chk(clk_cfg_o === CLK_RST, "R9 clk_cfg after warm reset", int'(clk_cfg_o), int'(CLK_RST));
      bus_op(1'b0, WIN_BASE + 10, 8'h00, "R9 window kept over warm reset");
      bus_op(1'b0, 100, 8'h00, "R9 low kept over warm reset");
      bus_op(1'b1, WIN_BASE + 12, 8'hD2, "R9");
      bus_op(1'b0, WIN_BASE + 12, 8'h00, "R9 lock cleared by reset");

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R10 all reads returned", sb.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule